// File: doc/BRIEF.md
# One-Way Inter-Processor Mailbox

This block carries messages from one processor (the sender) to another (the receiver). It holds a window of 32 word slots. Each side reaches the window through its own simple register port. The sender writes 32-bit message words. The receiver reads them and acknowledges them. A full two-way link uses two copies of the block, one facing each way.

Every data word has two status bits. The lock bit records that the word was written and the receiver has not yet read it. The sticky overwrite bit records that the sender wrote the word again while it was still locked. The two status words present these bits at the bit position of the slot number.

There are two classes of data word, and each signals the receiver in its own way:

- Bulk words: the sender fills several of them, then rings a doorbell. The doorbell raises a level interrupt that stays up until the receiver acknowledges it.
- Direct words: a write to one of these raises that word's own interrupt at once. The interrupt drops when the receiver reads the word.

Both ports read without delay: read data is a function of the address in the same cycle. State changes take effect at the next clock edge.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset, every slot reads 0x00000000 on both ports. `bulk_irq` and all `direct_irq` bits are low.
- R2: The slot map is as follows. Slot 0 is the doorbell, slot 1 is the lock-status word, slot 2 is the overwrite-status word and slot 3 is reserved. Slots 4..23 are bulk data words and slots 24..31 are direct data words. A sender write to a data slot stores `tx_wdata`, and either port then reads that value back from the slot.
- R3: A sender write to data slot n sets bit n of the lock-status word (slot 1). A receiver data read (`rx_rd_en`) of slot n clears that bit. Reading slot 1 or slot 2 through the receiver port changes no lock bit.
- R4: A sender write to data slot n while bit n of the lock-status word is 1 replaces the stored value and sets bit n of the overwrite-status word (slot 2). A write to an unlocked slot leaves that bit unchanged.
- R5: A sender write to slot 2 clears each overwrite bit whose `tx_wdata` bit is 0 and keeps each bit whose `tx_wdata` bit is 1.
- R6: A sender write to slot 0 with bit 0 set raises `bulk_irq` at the next edge. A write with bit 0 clear has no effect. Slot 0 always reads zero. `bulk_irq` stays high until `rx_bulk_ack` is sampled high. If a doorbell write and an acknowledge come in the same cycle, the doorbell wins.
- R7: A sender write to direct slot 24+k raises `direct_irq[k]` at the next edge and leaves the other bits alone. Bulk-slot writes raise no direct interrupt.
- R8: A receiver data read of direct slot 24+k clears `direct_irq[k]` at the next edge.
- R9: A sender write and a receiver read may hit the same data slot in the same cycle. In that case the read returns the old value, the lock bit ends at 1, and a direct interrupt stays high.
- R10: Slot 3 and bits 3..0 of slots 1 and 2 always read zero. Sender writes to slot 1 and slot 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr_en | input | 1 | Sender write strobe |
| tx_addr | input | AW (5) | Sender slot address |
| tx_wdata | input | DW (32) | Sender write data |
| tx_rdata | output | DW (32) | Sender read data for `tx_addr`; reading has no side effect |
| rx_rd_en | input | 1 | Receiver read strobe; releases the lock of a data slot |
| rx_addr | input | AW (5) | Receiver slot address |
| rx_rdata | output | DW (32) | Receiver read data for `rx_addr` |
| rx_bulk_ack | input | 1 | Receiver acknowledge that clears `bulk_irq` |
| bulk_irq | output | 1 | Doorbell interrupt to the receiver |
| direct_irq | output | N_DIRECT (8) | One interrupt per direct data word |

## Verification
The bench fills every one of the 28 data slots in turn with an arithmetic pattern. After each fill it checks the lock-status mask and the direct-interrupt mask. This tells the bulk slots apart from the direct slots and exposes any bit-position error in the status words. It then drains every slot through the receiver. This shows that only data reads release locks and interrupts, and that status-word reads do not. Repeated writes to a chosen set of locked and unlocked slots separate the overwrite path from a plain write. Mixed keep/clear masks on the overwrite word exercise the clear rule. Doorbell writes with bit 0 set and clear, acknowledges, and same-cycle write/read collisions on a bulk slot and on a direct slot cover the remaining ordering rules.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int CTRL_SLOTS = 4;
  localparam int SLOT_BELL  = 0;
  localparam int SLOT_LOCK  = 1;
  localparam int SLOT_OVR   = 2;

  typedef enum logic [1:0] {
    VIEW_ZERO,
    VIEW_LOCK,
    VIEW_OVR,
    VIEW_DATA
  } view_e;

  // What a given slot index presents on a read port.
  function automatic view_e slot_view(int unsigned idx, int unsigned n_data);
    if (idx == SLOT_LOCK) return VIEW_LOCK;
    if (idx == SLOT_OVR)  return VIEW_OVR;
    if (idx >= CTRL_SLOTS && idx < CTRL_SLOTS + n_data) return VIEW_DATA;
    return VIEW_ZERO;
  endfunction

  // Next overwrite bit for one data slot.
  function automatic logic ovr_next(logic cur, logic wr, logic locked,
                                    logic clr_we, logic keep);
    if (wr && locked) return 1'b1;
    if (clr_we)       return cur & keep;
    return cur;
  endfunction

endpackage

// File: rtl/mbx_slot_decode.sv
module mbx_slot_decode #(
  parameter int AW    = 5,
  parameter int BASE  = 4,
  parameter int COUNT = 28
) (
  input  logic             en,
  input  logic [AW-1:0]    addr,
  output logic [COUNT-1:0] hit
);
  for (genvar j = 0; j < COUNT; j++) begin : g_hit
    assign hit[j] = en && (addr == AW'(BASE + j));
  end
endmodule

// File: rtl/mbx_slot_bank.sv
module mbx_slot_bank
  import mbx_pkg::*;
#(
  parameter int DW     = 32,
  parameter int N_DATA = 28
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_DATA-1:0]            wr_hit,
  input  logic [N_DATA-1:0]            rd_hit,
  input  logic [DW-1:0]                wdata,
  input  logic                         ovr_we,
  input  logic [N_DATA-1:0]            ovr_keep,
  output logic [N_DATA-1:0][DW-1:0]    data_q,
  output logic [N_DATA-1:0]            lock_q,
  output logic [N_DATA-1:0]            ovr_q
);
  for (genvar j = 0; j < N_DATA; j++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[j] <= '0;
        lock_q[j] <= 1'b0;
        ovr_q[j]  <= 1'b0;
      end else begin
        if (wr_hit[j]) data_q[j] <= wdata;
        // a write in the same cycle as a read keeps the lock
        if (wr_hit[j])      lock_q[j] <= 1'b1;
        else if (rd_hit[j]) lock_q[j] <= 1'b0;
        ovr_q[j] <= ovr_next(ovr_q[j], wr_hit[j], lock_q[j], ovr_we, ovr_keep[j]);
      end
    end
  end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
  parameter int N_DIRECT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bell_set,
  input  logic                bell_ack,
  input  logic [N_DIRECT-1:0] dir_wr,
  input  logic [N_DIRECT-1:0] dir_rd,
  output logic                bulk_irq,
  output logic [N_DIRECT-1:0] direct_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bulk_irq <= 1'b0;
    else if (bell_set)  bulk_irq <= 1'b1;
    else if (bell_ack)  bulk_irq <= 1'b0;
  end

  for (genvar k = 0; k < N_DIRECT; k++) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         direct_irq[k] <= 1'b0;
      else if (dir_wr[k]) direct_irq[k] <= 1'b1;
      else if (dir_rd[k]) direct_irq[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
#(
  parameter int DW       = 32,
  parameter int N_BULK   = 20,
  parameter int N_DIRECT = 8,
  parameter int AW       = $clog2(CTRL_SLOTS + N_BULK + N_DIRECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_wr_en,
  input  logic [AW-1:0]       tx_addr,
  input  logic [DW-1:0]       tx_wdata,
  output logic [DW-1:0]       tx_rdata,
  input  logic                rx_rd_en,
  input  logic [AW-1:0]       rx_addr,
  output logic [DW-1:0]       rx_rdata,
  input  logic                rx_bulk_ack,
  output logic                bulk_irq,
  output logic [N_DIRECT-1:0] direct_irq
);
  localparam int N_DATA  = N_BULK + N_DIRECT;
  localparam int N_VIEW  = 2 ** AW;

  // named internal events, observed by the bound checker
  logic [N_DATA-1:0]         wr_hit;
  logic [N_DATA-1:0]         rd_hit;
  logic                      bell_set;
  logic                      ovr_we;
  logic [N_DATA-1:0][DW-1:0] data_q;
  logic [N_DATA-1:0]         lock_d;
  logic [N_DATA-1:0]         ovr_d;
  logic [DW-1:0]             lock_word;
  logic [DW-1:0]             ovr_word;
  logic [N_VIEW-1:0][DW-1:0] view;

  assign bell_set = tx_wr_en && (tx_addr == AW'(SLOT_BELL)) && tx_wdata[0];
  assign ovr_we   = tx_wr_en && (tx_addr == AW'(SLOT_OVR));

  mbx_slot_decode #(.AW(AW), .BASE(CTRL_SLOTS), .COUNT(N_DATA)) u_wr_dec (
    .en(tx_wr_en), .addr(tx_addr), .hit(wr_hit)
  );

  mbx_slot_decode #(.AW(AW), .BASE(CTRL_SLOTS), .COUNT(N_DATA)) u_rd_dec (
    .en(rx_rd_en), .addr(rx_addr), .hit(rd_hit)
  );

  mbx_slot_bank #(.DW(DW), .N_DATA(N_DATA)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (wr_hit),
    .rd_hit   (rd_hit),
    .wdata    (tx_wdata),
    .ovr_we   (ovr_we),
    .ovr_keep (tx_wdata[CTRL_SLOTS +: N_DATA]),
    .data_q   (data_q),
    .lock_q   (lock_d),
    .ovr_q    (ovr_d)
  );

  mbx_irq_gen #(.N_DIRECT(N_DIRECT)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bell_set   (bell_set),
    .bell_ack   (rx_bulk_ack),
    .dir_wr     (wr_hit[N_DATA-1 -: N_DIRECT]),
    .dir_rd     (rd_hit[N_DATA-1 -: N_DIRECT]),
    .bulk_irq   (bulk_irq),
    .direct_irq (direct_irq)
  );

  always_comb begin
    lock_word = '0;
    ovr_word  = '0;
    lock_word[CTRL_SLOTS +: N_DATA] = lock_d;
    ovr_word[CTRL_SLOTS +: N_DATA]  = ovr_d;
  end

  for (genvar i = 0; i < N_VIEW; i++) begin : g_view
    if (slot_view(i, N_DATA) == VIEW_LOCK) begin : g_lock
      assign view[i] = lock_word;
    end else if (slot_view(i, N_DATA) == VIEW_OVR) begin : g_ovr
      assign view[i] = ovr_word;
    end else if (slot_view(i, N_DATA) == VIEW_DATA) begin : g_data
      assign view[i] = data_q[i - CTRL_SLOTS];
    end else begin : g_zero
      assign view[i] = '0;
    end
  end

  assign tx_rdata = view[tx_addr];
  assign rx_rdata = view[rx_addr];

endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
  parameter int DW       = 32,
  parameter int N_DATA   = 28,
  parameter int N_DIRECT = 8,
  parameter int AW       = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tx_wr_en,
  input logic [AW-1:0]       tx_addr,
  input logic [DW-1:0]       tx_wdata,
  input logic [AW-1:0]       rx_addr,
  input logic [DW-1:0]       rx_rdata,
  input logic                rx_bulk_ack,
  input logic                bulk_irq,
  input logic [N_DIRECT-1:0] direct_irq,
  input logic [N_DATA-1:0]   wr_hit,
  input logic [N_DATA-1:0]   rd_hit,
  input logic [N_DATA-1:0]   lock_d,
  input logic [N_DATA-1:0]   ovr_d
);
  localparam int DBASE = N_DATA - N_DIRECT;

  for (genvar j = 0; j < N_DATA; j++) begin : g_data
    p_lock_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[j] |=> lock_d[j]);
    p_lock_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit[j] && !wr_hit[j] |=> !lock_d[j]);
    p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[j] && lock_d[j] |=> ovr_d[j]);
  end

  for (genvar k = 0; k < N_DIRECT; k++) begin : g_dir
    p_direct_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[DBASE + k] |=> direct_irq[k]);
    p_direct_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit[DBASE + k] && !wr_hit[DBASE + k] |=> !direct_irq[k]);
  end

  p_bell_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_en && tx_addr == '0 && tx_wdata[0] |=> bulk_irq);
  p_bulk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_irq && !rx_bulk_ack |=> bulk_irq);
  p_rsvd_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_addr == AW'(3) |-> rx_rdata == '0);
endmodule

bind mbx_mailbox mbx_mailbox_chk #(
  .DW(DW), .N_DATA(N_DATA), .N_DIRECT(N_DIRECT), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr_en(tx_wr_en), .tx_addr(tx_addr),
  .tx_wdata(tx_wdata), .rx_addr(rx_addr), .rx_rdata(rx_rdata),
  .rx_bulk_ack(rx_bulk_ack), .bulk_irq(bulk_irq), .direct_irq(direct_irq),
  .wr_hit(wr_hit), .rd_hit(rd_hit), .lock_d(lock_d), .ovr_d(ovr_d)
);

// File: tb/tb_mbx_mailbox.sv
`timescale 1ns/1ps
module tb_mbx_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_wr_en = 1'b0;
  logic [4:0]  tx_addr = '0;
  logic [31:0] tx_wdata = '0;
  logic [31:0] tx_rdata;
  logic        rx_rd_en = 1'b0;
  logic [4:0]  rx_addr = '0;
  logic [31:0] rx_rdata;
  logic        rx_bulk_ack = 1'b0;
  logic        bulk_irq;
  logic [7:0]  direct_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbx_mailbox dut (
    .clk(clk), .rst_n(rst_n), .tx_wr_en(tx_wr_en), .tx_addr(tx_addr),
    .tx_wdata(tx_wdata), .tx_rdata(tx_rdata), .rx_rd_en(rx_rd_en),
    .rx_addr(rx_addr), .rx_rdata(rx_rdata), .rx_bulk_ack(rx_bulk_ack),
    .bulk_irq(bulk_irq), .direct_irq(direct_irq)
  );

  function automatic logic [31:0] pat(int n);
    return (32'h9E3779B9 * n) ^ 32'h00C0FFEE;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tx_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    tx_wr_en = 1'b1; tx_addr = 5'(a); tx_wdata = d;
    @(negedge clk);
    tx_wr_en = 1'b0;
  endtask

  task automatic tx_peek(input int a, output logic [31:0] d);
    tx_addr = 5'(a);
    #1 d = tx_rdata;
  endtask

  task automatic rx_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rx_rd_en = 1'b1; rx_addr = 5'(a);
    #1 d = rx_rdata;
    @(negedge clk);
    rx_rd_en = 1'b0;
  endtask

  task automatic collide(input int a, input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    tx_wr_en = 1'b1; tx_addr = 5'(a); tx_wdata = d;
    rx_rd_en = 1'b1; rx_addr = 5'(a);
    #1 r = rx_rdata;
    @(negedge clk);
    tx_wr_en = 1'b0; rx_rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp_lock;
    logic [31:0] exp_ovr;
    logic [31:0] exp_data [32];
    logic [7:0]  exp_dir;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state on both ports
    for (int s = 0; s < 32; s++) begin
      tx_peek(s, v); check("R1 tx reset", v, 32'h0);
      rx_addr = 5'(s); #1 check("R1 rx reset", rx_rdata, 32'h0);
    end
    check("R1 bulk_irq", {31'h0, bulk_irq}, 32'h0);
    check("R1 direct_irq", {24'h0, direct_irq}, 32'h0);

    // R2, R3, R7: fill every data slot, track lock and direct masks
    exp_lock = '0; exp_ovr = '0; exp_dir = '0;
    for (int n = 4; n < 32; n++) begin
      exp_data[n] = pat(n);
      tx_wr(n, exp_data[n]);
      exp_lock[n] = 1'b1;
      if (n >= 24) exp_dir[n-24] = 1'b1;
      tx_peek(1, v); check("R3 lock mask after fill", v, exp_lock);
      check("R7 direct mask after fill", {24'h0, direct_irq}, {24'h0, exp_dir});
      tx_peek(n, v); check("R2 tx readback", v, exp_data[n]);
    end
    tx_peek(2, v); check("R4 no overwrite on fresh writes", v, exp_ovr);
    check("R6 no bulk irq from data writes", {31'h0, bulk_irq}, 32'h0);

    // R3: status reads through receiver do not release locks
    rx_rd(1, v); check("R3 rx lock word read", v, exp_lock);
    rx_rd(2, v); check("R3 rx ovr word read", v, exp_ovr);
    tx_peek(1, v); check("R3 locks kept after status read", v, exp_lock);

    // R4: rewrite locked slots
    for (int i = 0; i < 4; i++) begin
      int s;
      s = (i == 0) ? 4 : (i == 1) ? 17 : (i == 2) ? 24 : 31;
      exp_data[s] = ~pat(s);
      tx_wr(s, exp_data[s]);
      exp_ovr[s] = 1'b1;
      tx_peek(s, v); check("R4 new data replaces", v, exp_data[s]);
      tx_peek(2, v); check("R4 ovr mask", v, exp_ovr);
    end

    // R5: keep 17 and 31, clear others
    tx_wr(2, 32'h8002_0000);
    exp_ovr = 32'h8002_0000;
    tx_peek(2, v); check("R5 ovr clear mask", v, exp_ovr);
    tx_wr(2, 32'h7FFF_FFFF);
    exp_ovr[31] = 1'b0;
    tx_peek(2, v); check("R5 ovr clear bit31", v, exp_ovr);

    // R2, R3, R8: drain every data slot through the receiver
    for (int n = 4; n < 32; n++) begin
      rx_rd(n, v); check("R2 rx data", v, exp_data[n]);
      exp_lock[n] = 1'b0;
      if (n >= 24) exp_dir[n-24] = 1'b0;
      tx_peek(1, v); check("R3 lock released", v, exp_lock);
      check("R8 direct mask after read", {24'h0, direct_irq}, {24'h0, exp_dir});
    end
    tx_peek(2, v); check("R4 ovr unaffected by reads", v, exp_ovr);
    tx_wr(9, 32'h1234_5678);
    exp_lock[9] = 1'b1; exp_data[9] = 32'h1234_5678;
    tx_peek(2, v); check("R4 unlocked write no ovr", v, exp_ovr);
    rx_rd(9, v); exp_lock[9] = 1'b0;

    // R6: doorbell
    tx_wr(0, 32'hFFFF_FFFE);
    check("R6 bit0 clear no irq", {31'h0, bulk_irq}, 32'h0);
    tx_peek(0, v); check("R6 doorbell reads zero", v, 32'h0);
    tx_wr(0, 32'h0000_0001);
    check("R6 doorbell raises", {31'h0, bulk_irq}, 32'h1);
    tx_peek(0, v); check("R6 doorbell reads zero after set", v, 32'h0);
    repeat (5) @(negedge clk);
    check("R6 irq holds", {31'h0, bulk_irq}, 32'h1);
    @(negedge clk); rx_bulk_ack = 1'b1;
    @(negedge clk); rx_bulk_ack = 1'b0;
    check("R6 ack clears", {31'h0, bulk_irq}, 32'h0);
    @(negedge clk);
    tx_wr_en = 1'b1; tx_addr = 5'd0; tx_wdata = 32'h1; rx_bulk_ack = 1'b1;
    @(negedge clk);
    tx_wr_en = 1'b0; rx_bulk_ack = 1'b0;
    check("R6 set wins over ack", {31'h0, bulk_irq}, 32'h1);
    @(negedge clk); rx_bulk_ack = 1'b1;
    @(negedge clk); rx_bulk_ack = 1'b0;
    check("R6 second ack clears", {31'h0, bulk_irq}, 32'h0);
    check("R7 bulk path leaves direct", {24'h0, direct_irq}, 32'h0);

    // R9: same-cycle write and read
    tx_wr(10, 32'hAAAA_0010); exp_lock[10] = 1'b1;
    collide(10, 32'hBBBB_0010, v);
    check("R9 read returns old data", v, 32'hAAAA_0010);
    exp_ovr[10] = 1'b1;
    tx_peek(1, v); check("R9 lock kept", v, exp_lock);
    tx_peek(2, v); check("R9 ovr set", v, exp_ovr);
    tx_peek(10, v); check("R9 new data stored", v, 32'hBBBB_0010);
    tx_wr(26, 32'hCCCC_0026); exp_lock[26] = 1'b1;
    collide(26, 32'hDDDD_0026, v);
    check("R9 direct read returns old", v, 32'hCCCC_0026);
    check("R9 direct irq kept", {24'h0, direct_irq}, 32'h0000_0004);
    exp_ovr[26] = 1'b1;
    tx_peek(1, v); check("R9 direct lock kept", v, exp_lock);

    // R10: reserved slot and read-only status word
    tx_wr(3, 32'hFFFF_FFFF);
    tx_wr(1, 32'hFFFF_FFFF);
    tx_peek(3, v); check("R10 reserved slot zero", v, 32'h0);
    rx_rd(3, v); check("R10 rx reserved slot zero", v, 32'h0);
    tx_peek(1, v); check("R10 lock word unchanged", v, exp_lock);
    tx_peek(2, v); check("R10 ovr word unchanged", v, exp_ovr);
    check("R10 low bits zero", v & 32'hF, 32'h0);
    check("R10 no irq from reserved", {23'h0, bulk_irq, direct_irq}, 32'h0000_0004);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule